// File: doc/BRIEF.md
# Vector Sign and Nonzero Mask Extractor

This execution unit sits in a 128-bit SIMD datapath. Each accepted operation carries a 32-bit instruction word and a 128-bit source vector. The unit decodes one of six mask-extraction operations and returns a 128-bit result. The result holds a compact predicate mask with one bit per element. Depending on the operation, each bit reflects either the element's sign bit or whether the element is nonzero.

Element widths of 8, 16, 32 and 64 bits are supported. The mask always starts at result bit 0, and every bit above the mask field is driven to zero. The destination register index is taken from the instruction and returned alongside the result. Input valid and all outputs are registered, so there is exactly one cycle of latency. An instruction word that matches none of the six encodings is flagged as illegal and returns an all-zero result.

Top module: `vmask_unit`

## Requirements
- R1: An instruction is legal only when bits 31:15 equal 0111_00101001_11000 and bits 14:10 hold one of 10000, 10001, 10010, 10011, 10100 or 11000. Any other word raises out_illegal together with out_valid and returns an all-zero result.
- R2: out_valid is high in the cycle after each cycle in which in_valid is high, and low otherwise. A synchronous active-high reset clears out_valid.
- R3: Selector 10000 returns a 16-bit mask in which result bit i equals bit 8*i+7 of the source (byte i, numbered from the least significant end).
- R4: Selector 10001 returns an 8-bit mask in which result bit i equals bit 16*i+15 of the source.
- R5: Selector 10010 returns a 4-bit mask in which result bit i equals bit 32*i+31 of the source.
- R6: Selector 10011 returns a 2-bit mask in which result bit i equals bit 64*i+63 of the source.
- R7: Selector 10100 returns, in bits 15:0, the bitwise inverse of the byte sign mask of R3. Bits 15:0 are therefore set for bytes that are not negative.
- R8: Selector 11000 sets result bit i (i from 0 to 15) exactly when byte i of the source is not zero.
- R9: For every operation, every result bit above the operation's mask field is zero, including the whole upper 64-bit half.
- R10: out_dest equals instruction bits 4:0 of the accepted operation. Instruction bits 9:5 (the source register index) have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation offered this cycle |
| in_insn | input | 32 | Instruction word |
| in_src | input | 128 | Source vector |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| out_result | output | 128 | Packed mask result |
| out_dest | output | 5 | Destination register index from the instruction |
| out_illegal | output | 1 | Instruction word not recognised |

## Verification
The bench builds the unit with its default 128-bit vector, 32-bit instruction and 5-bit index parameters, since the encodings are fixed at these sizes. With this configuration, all 32 values of the operation selector can be swept exhaustively, and corrupted prefixes can be added. Every single-byte position can also be exercised at both sign polarities against all six operations. Fixed sign patterns, all-zero and all-ones vectors, and random vectors are run as well. Every result is compared against a per-element model computed in the bench.

// File: rtl/vmask_pkg.sv
package vmask_pkg;

    localparam int VEC_W    = 128;
    localparam int INSN_W   = 32;
    localparam int IDX_W    = 5;
    localparam int BYTE_W   = 8;
    localparam int LANES_MAX = VEC_W / BYTE_W;
    localparam int N_WIDTHS = 4;

    localparam logic [16:0] OPC_PREFIX = 17'b0111_00101001_11000;

    typedef enum logic [2:0] {
        OP_SGN_B = 3'd0,
        OP_SGN_H = 3'd1,
        OP_SGN_W = 3'd2,
        OP_SGN_D = 3'd3,
        OP_GEZ_B = 3'd4,
        OP_NZ_B  = 3'd5,
        OP_ILL   = 3'd7
    } mask_op_e;

    typedef struct packed {
        logic               illegal;
        logic [IDX_W-1:0]   dest;
        logic [VEC_W-1:0]   data;
    } mask_res_t;

    function automatic mask_op_e decode_op(input logic [INSN_W-1:0] insn);
        mask_op_e op;
        if (insn[31:15] != OPC_PREFIX) begin
            op = OP_ILL;
        end else begin
            case (insn[14:10])
                5'b10000: op = OP_SGN_B;
                5'b10001: op = OP_SGN_H;
                5'b10010: op = OP_SGN_W;
                5'b10011: op = OP_SGN_D;
                5'b10100: op = OP_GEZ_B;
                5'b11000: op = OP_NZ_B;
                default:  op = OP_ILL;
            endcase
        end
        return op;
    endfunction

endpackage

// File: rtl/vmask_decode.sv
module vmask_decode
    import vmask_pkg::*;
(
    input  logic [INSN_W-1:0] insn,
    output mask_op_e          op,
    output logic [IDX_W-1:0]  dest
);
    logic [IDX_W-1:0] unused_src_idx;

    assign unused_src_idx = insn[2*IDX_W-1:IDX_W];
    assign op             = decode_op(insn);
    assign dest           = insn[IDX_W-1:0];
endmodule

// File: rtl/vmask_sign_pack.sv
module vmask_sign_pack #(
    parameter int VEC_W  = 128,
    parameter int ELEM_W = 8,
    parameter int OUT_W  = 16
) (
    input  logic [VEC_W-1:0] src,
    output logic [OUT_W-1:0] mask
);
    localparam int LANES = VEC_W / ELEM_W;

    logic unused_bits;
    assign unused_bits = ^src;

    for (genvar i = 0; i < OUT_W; i++) begin : g_lane
        if (i < LANES) begin : g_live
            assign mask[i] = src[i*ELEM_W + ELEM_W - 1];
        end else begin : g_pad
            assign mask[i] = 1'b0;
        end
    end
endmodule

// File: rtl/vmask_nz_pack.sv
module vmask_nz_pack #(
    parameter int VEC_W  = 128,
    parameter int BYTE_W = 8
) (
    input  logic [VEC_W-1:0]        src,
    output logic [VEC_W/BYTE_W-1:0] mask
);
    localparam int LANES = VEC_W / BYTE_W;

    for (genvar i = 0; i < LANES; i++) begin : g_byte
        assign mask[i] = |src[i*BYTE_W +: BYTE_W];
    end
endmodule

// File: rtl/vmask_unit.sv
module vmask_unit
    import vmask_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [INSN_W-1:0] in_insn,
    input  logic [VEC_W-1:0]  in_src,
    output logic              out_valid,
    output logic [VEC_W-1:0]  out_result,
    output logic [IDX_W-1:0]  out_dest,
    output logic              out_illegal
);
    mask_op_e             op;
    logic [IDX_W-1:0]     dest;
    logic [LANES_MAX-1:0] sgn_mask [N_WIDTHS];
    logic [LANES_MAX-1:0] nz_mask;
    mask_res_t            res_next;
    mask_res_t            res_q;
    logic                 valid_q;

    vmask_decode u_dec (
        .insn (in_insn),
        .op   (op),
        .dest (dest)
    );

    for (genvar g = 0; g < N_WIDTHS; g++) begin : g_width
        vmask_sign_pack #(
            .VEC_W  (VEC_W),
            .ELEM_W (BYTE_W << g),
            .OUT_W  (LANES_MAX)
        ) u_sgn (
            .src  (in_src),
            .mask (sgn_mask[g])
        );
    end

    vmask_nz_pack #(
        .VEC_W  (VEC_W),
        .BYTE_W (BYTE_W)
    ) u_nz (
        .src  (in_src),
        .mask (nz_mask)
    );

    always_comb begin
        res_next         = '0;
        res_next.dest    = dest;
        res_next.illegal = (op == OP_ILL);
        case (op)
            OP_SGN_B: res_next.data[LANES_MAX-1:0] = sgn_mask[0];
            OP_SGN_H: res_next.data[LANES_MAX-1:0] = sgn_mask[1];
            OP_SGN_W: res_next.data[LANES_MAX-1:0] = sgn_mask[2];
            OP_SGN_D: res_next.data[LANES_MAX-1:0] = sgn_mask[3];
            OP_GEZ_B: res_next.data[LANES_MAX-1:0] = ~sgn_mask[0];
            OP_NZ_B:  res_next.data[LANES_MAX-1:0] = nz_mask;
            default:  res_next.data = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            res_q   <= '0;
        end else begin
            valid_q <= in_valid;
            if (in_valid) begin
                res_q <= res_next;
            end
        end
    end

    assign out_valid   = valid_q;
    assign out_result  = res_q.data;
    assign out_dest    = res_q.dest;
    assign out_illegal = res_q.illegal;
endmodule

// File: rtl/vmask_unit_chk.sv
module vmask_unit_chk
    import vmask_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [INSN_W-1:0] in_insn,
    input logic [VEC_W-1:0]  in_src,
    input logic              out_valid,
    input logic [VEC_W-1:0]  out_result,
    input logic [IDX_W-1:0]  out_dest,
    input logic              out_illegal
);
    // R2
    valid_follows_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R2
    valid_drops_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R1
    illegal_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_illegal) |-> (out_result == '0));

    // R1
    bad_prefix_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_insn[31:15] != OPC_PREFIX) |=> out_illegal);

    // R9
    high_zero_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_result[VEC_W-1:LANES_MAX] == '0));

    // R10
    dest_pass_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (out_dest == $past(in_insn[IDX_W-1:0])));

    // R7
    gez_inverse_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_insn[31:10] == {OPC_PREFIX, 5'b10100} && in_src[7])
        |=> !out_result[0]);

    logic unused_in;
    assign unused_in = ^in_src[VEC_W-1:8] ^ ^in_src[6:0];
endmodule

bind vmask_unit vmask_unit_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_insn     (in_insn),
    .in_src      (in_src),
    .out_valid   (out_valid),
    .out_result  (out_result),
    .out_dest    (out_dest),
    .out_illegal (out_illegal)
);

// File: tb/sim_vmask_unit.sv
`timescale 1ns/1ps
module sim_vmask_unit;
    localparam logic [16:0] PREFIX = 17'b0111_00101001_11000;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [31:0]  in_insn = '0;
    logic [127:0] in_src = '0;
    logic         out_valid;
    logic [127:0] out_result;
    logic [4:0]   out_dest;
    logic         out_illegal;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    vmask_unit u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_insn(in_insn),
        .in_src(in_src), .out_valid(out_valid), .out_result(out_result),
        .out_dest(out_dest), .out_illegal(out_illegal)
    );

    function automatic logic [127:0] model(input logic [4:0] sel, input logic [127:0] v);
        logic [127:0] r = '0;
        case (sel)
            5'b10000: for (int i = 0; i < 16; i++) r[i] = v[8*i+7];
            5'b10001: for (int i = 0; i < 8; i++)  r[i] = v[16*i+15];
            5'b10010: for (int i = 0; i < 4; i++)  r[i] = v[32*i+31];
            5'b10011: for (int i = 0; i < 2; i++)  r[i] = v[64*i+63];
            5'b10100: for (int i = 0; i < 16; i++) r[i] = ~v[8*i+7];
            5'b11000: for (int i = 0; i < 16; i++) r[i] = (v[8*i +: 8] != 8'h00);
            default:  r = '0;
        endcase
        return r;
    endfunction

    function automatic string req_of(input logic [4:0] sel);
        case (sel)
            5'b10000: return "R3";
            5'b10001: return "R4";
            5'b10010: return "R5";
            5'b10011: return "R6";
            5'b10100: return "R7";
            5'b11000: return "R8";
            default:  return "R1";
        endcase
    endfunction

    function automatic bit legal_sel(input logic [4:0] sel);
        return sel inside {5'b10000, 5'b10001, 5'b10010, 5'b10011, 5'b10100, 5'b11000};
    endfunction

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_op(input logic [16:0] pfx, input logic [4:0] sel,
                          input logic [4:0] sidx, input logic [4:0] didx,
                          input logic [127:0] v, output logic [127:0] got);
        bit ok;
        logic [127:0] exp;
        @(negedge clk);
        in_valid = 1'b1;
        in_insn  = {pfx, sel, sidx, didx};
        in_src   = v;
        @(negedge clk);
        in_valid = 1'b0;
        ok  = (pfx == PREFIX) && legal_sel(sel);
        exp = ok ? model(sel, v) : '0;
        check("R2", {127'd0, out_valid}, 128'd1);
        check(ok ? req_of(sel) : "R1", out_result, exp);
        check("R1", {127'd0, out_illegal}, {127'd0, !ok});
        check("R9", {16'd0, out_result[127:16]}, 128'd0);
        check("R10", {123'd0, out_dest}, {123'd0, didx});
        got = out_result;
    endtask

    function automatic logic [127:0] pattern(input int k);
        case (k)
            0: return '0;
            1: return '1;
            2: return {16{8'h80}};
            3: return {8{16'h8000}};
            4: return {8{16'h0080}};
            5: return {4{32'h8000_0000}};
            6: return {2{64'h8000_0000_0000_0000}};
            7: return {16{8'hA5}};
            8: return {16{8'h7F}};
            9: return {4{32'h00FF_80_01}};
            default: return '0;
        endcase
    endfunction

    localparam logic [4:0] SELS [6] = '{5'b10000, 5'b10001, 5'b10010,
                                        5'b10011, 5'b10100, 5'b11000};

    initial begin
        logic [127:0] g1;
        logic [127:0] g2;
        logic [127:0] v;
        repeat (3) @(negedge clk);
        check("R2", {127'd0, out_valid}, 128'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R2", {127'd0, out_valid}, 128'd0);

        // R3-style fixed patterns per operation (each check names its own tag)
        for (int s = 0; s < 6; s++)
            for (int k = 0; k < 10; k++)
                run_op(PREFIX, SELS[s], 5'(k), 5'(k + s), pattern(k), g1);

        // single nonzero byte at every position, both polarities
        for (int s = 0; s < 6; s++)
            for (int p = 0; p < 16; p++)
                for (int pol = 0; pol < 2; pol++) begin
                    v = 128'(pol ? 8'h80 : 8'h01) << (8 * p);
                    run_op(PREFIX, SELS[s], 5'(p), 5'(31 - p), v, g1);
                end

        // R1: exhaustive selector sweep with a mixed vector
        for (int sel = 0; sel < 32; sel++)
            run_op(PREFIX, 5'(sel), 5'd3, 5'(sel), pattern(9), g1);

        // R1: corrupted prefix with otherwise legal selectors
        for (int b = 0; b < 17; b++)
            run_op(PREFIX ^ (17'd1 << b), SELS[b % 6], 5'd1, 5'd2, '1, g1);

        // random vectors, with R10 source-index independence
        for (int n = 0; n < 150; n++) begin
            v = {$urandom(), $urandom(), $urandom(), $urandom()};
            for (int s = 0; s < 6; s++) begin
                run_op(PREFIX, SELS[s], 5'd0, 5'(n), v, g1);
                run_op(PREFIX, SELS[s], 5'd31, 5'(n + 1), v, g2);
                check("R10", g2, g1);
            end
        end

        // R2: valid drops when no operation is offered
        @(negedge clk);
        check("R2", {127'd0, out_valid}, 128'd0);

        // R2: back-to-back operations
        @(negedge clk);
        in_valid = 1'b1;
        in_insn  = {PREFIX, 5'b10000, 5'd0, 5'd7};
        in_src   = {16{8'h80}};
        @(negedge clk);
        in_insn  = {PREFIX, 5'b11000, 5'd0, 5'd9};
        in_src   = '0;
        check("R3", out_result, 128'hFFFF);
        @(negedge clk);
        in_valid = 1'b0;
        check("R2", {127'd0, out_valid}, 128'd1);
        check("R8", out_result, 128'd0);
        @(negedge clk);
        check("R2", {127'd0, out_valid}, 128'd0);

        // R2: reset clears valid
        @(negedge clk);
        in_valid = 1'b1;
        rst = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        rst = 1'b0;
        check("R2", {127'd0, out_valid}, 128'd0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule